// File: doc/BRIEF.md
# Third-Order Notch-Tuned Delta-Sigma Modulator

This block is a bit-exact, fixed-point, discrete-time model of a single-loop, third-order delta-sigma modulator. It uses the cascade-of-integrators feedback arrangement and a one-bit quantizer. The design has three delaying integrators. Every integrator takes a weighted copy of the fed-back ±1 decision. A small local feedback term, from the third integrator back into the second, moves a zero of the noise transfer function onto the signal tone. With an oversampling ratio of 128, a 5.12 MHz sample rate gives a 20 kHz tone.

For each valid multi-bit input sample, the block produces one output bit at the oversampled rate. A calibration mode adds a second signed tone sample straight onto the quantizer input, after the last integrator. That tone is shaped by the noise transfer function in the same way as quantization noise. An external tuning loop can watch the residual tone in the bit stream and trim the sample clock.

The resonator coefficient can be scaled by a percentage parameter. This makes it possible to model a mistuned notch.

Top module: `dsm3_notch_mod`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all three integrator states to zero and sets `bit_o` and `bit_vld_o` to 0.
- R2: `bit_vld_o` is high in the cycle after each rising edge where `smp_vld_i` was high. It is low in the cycle after any edge where `smp_vld_i` was low.
- R3: Let y be the third integrator state plus the tone term. The quantizer output is 1 when y ≥ 0 and 0 when y < 0. A bit of 1 feeds back as +1 and a bit of 0 feeds back as −1. The decision made at an accepted edge appears on `bit_o` in the following cycle.
- R4: Integrator states are signed 32-bit values with 24 fractional bits. Input samples are signed 16-bit values with 15 fractional bits. On an accepted sample, x1 gains (u·B1)·2 − v·A0·2^16, with B1 = 58 and A0 = 108.
- R5: On an accepted sample, x2 gains x1 − v·A1·2^16 − floor(x3·K1/2^24), with A1 = 156. K1 = floor(5243·K1_PCT/100), where 5243 is about 0.08/256 in units of 2^-24.
- R6: On an accepted sample, x3 gains floor(x2·B2/2^8) − v·A2·2^16, with B2 = 48 and A2 = 80. All three updates use the states from before the edge.
- R7: Each integrator saturates to the range [−2^31, 2^31−1] instead of wrapping.
- R8: When `cal_en_i` is high, tone·2^9 is added to the quantizer input only. When `cal_en_i` is low, `tone_i` has no effect on the output.
- R9: With `smp_vld_i` low, all states and `bit_o` hold their values.
- R10: The parameter `K1_PCT` scales the resonator coefficient. At 50 it gives K1 = 2621.
- R11: The control machine has four states:
  - IDLE: no sample since reset.
  - CONV: the last edge took a normal sample.
  - CAL: the last edge took a sample with calibration on.
  - HOLD: there was no sample at the last edge after at least one earlier sample.
  
  From any state, a sample with calibration on goes to CAL and a normal sample goes to CONV. Without a sample, IDLE stays in IDLE and every other state goes to HOLD. `bit_vld_o` is high exactly in CONV and CAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld_i | input | 1 | Input sample valid |
| smp_i | input | 16 | Signed input sample, 15 fractional bits |
| cal_en_i | input | 1 | Calibration tone enable |
| tone_i | input | 16 | Signed calibration tone sample, 15 fractional bits |
| bit_o | output | 1 | Modulator output bit (1 means +1) |
| bit_vld_o | output | 1 | Output bit valid |

## Verification
The hardest condition to reach from the ports is an integrator sitting at its saturation limit. The feedback works to pull the loop away from that limit. To get there, the stimulus holds a full-scale positive input for a long run and then steps to full-scale negative. The run is compared bit by bit against a model of the update equations that saturates exactly as R7 describes. A second instance with the resonator at half strength runs on the same stimulus. This shows that the scaled coefficient changes the stream in the way the equations predict.

// File: rtl/dsm3_pkg.sv
package dsm3_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_CAL  = 2'd2,
        ST_HOLD = 2'd3
    } dsm_state_t;

    localparam int COEF_FRAC = 8;
    localparam int K1_FRAC   = 24;
    localparam int K1_NOM    = 5243;

endpackage

// File: rtl/dsm3_integ.sv
module dsm3_integ #(
    parameter int SW = 32,
    parameter int AW = SW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [AW-1:0] add,
    output logic signed [SW-1:0] st
);
    localparam int XW = AW - SW + 2;
    localparam logic signed [AW:0] MAXV = {{XW{1'b0}}, {(SW-1){1'b1}}};
    localparam logic signed [AW:0] MINV = {{XW{1'b1}}, {(SW-1){1'b0}}};

    logic signed [AW:0] sum;
    logic signed [SW-1:0] st_nxt;

    always_comb begin
        sum = {{(AW+1-SW){st[SW-1]}}, st} + {add[AW-1], add};
        if (sum > MAXV)
            st_nxt = MAXV[SW-1:0];
        else if (sum < MINV)
            st_nxt = MINV[SW-1:0];
        else
            st_nxt = sum[SW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= '0;
        else if (en)
            st <= st_nxt;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (st == '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(st));

    assert_no_wrap_up_R7: assert property (@(posedge clk) disable iff (rst)
        (en && add > 0) |=> (st >= $past(st)));

    assert_no_wrap_dn_R7: assert property (@(posedge clk) disable iff (rst)
        (en && add < 0) |=> (st <= $past(st)));

endmodule

// File: rtl/dsm3_quant.sv
module dsm3_quant #(
    parameter int SW    = 32,
    parameter int IN_W  = 16,
    parameter int SH_T  = 9
) (
    input  logic signed [SW-1:0]   x3,
    input  logic signed [IN_W-1:0] tone,
    input  logic                   cal_en,
    output logic                   q
);
    logic signed [SW:0] tone_term;
    logic signed [SW:0] y;

    always_comb begin
        tone_term = cal_en ? ((SW+1)'(tone) <<< SH_T) : '0;
        y         = {x3[SW-1], x3} + tone_term;
        q         = !y[SW];
    end

endmodule

// File: rtl/dsm3_ctrl.sv
module dsm3_ctrl
    import dsm3_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       smp_vld,
    input  logic       cal_en,
    input  logic       q,
    output dsm_state_t state,
    output logic       bit_o,
    output logic       bit_vld
);
    dsm_state_t state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: state_nxt = smp_vld ? (cal_en ? ST_CAL : ST_CONV) : ST_IDLE;
            ST_CONV,
            ST_CAL,
            ST_HOLD: state_nxt = smp_vld ? (cal_en ? ST_CAL : ST_CONV) : ST_HOLD;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bit_o <= 1'b0;
        else if (smp_vld)
            bit_o <= q;
    end

    assign bit_vld = (state == ST_CONV) || (state == ST_CAL);

    assert_cal_state_R11: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && cal_en) |=> (state == ST_CAL));

    assert_conv_state_R11: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && !cal_en) |=> (state == ST_CONV));

    assert_idle_stays_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !smp_vld) |=> (state == ST_IDLE));

    assert_bit_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(bit_o));

endmodule

// File: rtl/dsm3_notch_mod.sv
module dsm3_notch_mod
    import dsm3_pkg::*;
#(
    parameter int IN_W    = 16,
    parameter int IN_FRAC = 15,
    parameter int SW      = 32,
    parameter int FRAC    = 24,
    parameter int A0      = 108,
    parameter int A1      = 156,
    parameter int A2      = 80,
    parameter int B1      = 58,
    parameter int B2      = 48,
    parameter int K1_PCT  = 100
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   smp_vld_i,
    input  logic signed [IN_W-1:0] smp_i,
    input  logic                   cal_en_i,
    input  logic signed [IN_W-1:0] tone_i,
    output logic                   bit_o,
    output logic                   bit_vld_o
);
    localparam int AW     = SW + 2;
    localparam int PW     = SW + 16;
    localparam int SH_U   = FRAC - IN_FRAC - COEF_FRAC;
    localparam int SH_C   = FRAC - COEF_FRAC;
    localparam int SH_T   = FRAC - IN_FRAC;
    localparam int K1_EFF = (K1_NOM * K1_PCT) / 100;

    localparam logic signed [AW-1:0] A0_S = AW'(A0 * (2 ** SH_C));
    localparam logic signed [AW-1:0] A1_S = AW'(A1 * (2 ** SH_C));
    localparam logic signed [AW-1:0] A2_S = AW'(A2 * (2 ** SH_C));
    localparam logic signed [AW-1:0] B1_S = AW'(B1);
    localparam logic signed [PW-1:0] B2_S = PW'(B2);
    localparam logic signed [PW-1:0] K1_S = PW'(K1_EFF);

    logic signed [SW-1:0] x1, x2, x3;
    logic signed [AW-1:0] add1, add2, add3;
    logic signed [AW-1:0] u_ext, fb0, fb1, fb2, k_term, b2_term;
    logic signed [PW-1:0] x2_ext, x3_ext, k_prod, b2_prod;
    logic                 q;
    dsm_state_t           state;

    dsm3_quant #(.SW(SW), .IN_W(IN_W), .SH_T(SH_T)) quant_i (
        .x3(x3), .tone(tone_i), .cal_en(cal_en_i), .q(q)
    );

    always_comb begin
        u_ext   = AW'(smp_i);
        fb0     = q ? A0_S : -A0_S;
        fb1     = q ? A1_S : -A1_S;
        fb2     = q ? A2_S : -A2_S;
        x2_ext  = PW'(x2);
        x3_ext  = PW'(x3);
        k_prod  = x3_ext * K1_S;
        b2_prod = x2_ext * B2_S;
        k_term  = AW'(k_prod >>> K1_FRAC);
        b2_term = AW'(b2_prod >>> COEF_FRAC);
        add1    = ((u_ext * B1_S) <<< SH_U) - fb0;
        add2    = AW'(x1) - fb1 - k_term;
        add3    = b2_term - fb2;
    end

    dsm3_integ #(.SW(SW), .AW(AW)) integ1_i (
        .clk(clk), .rst(rst), .en(smp_vld_i), .add(add1), .st(x1)
    );
    dsm3_integ #(.SW(SW), .AW(AW)) integ2_i (
        .clk(clk), .rst(rst), .en(smp_vld_i), .add(add2), .st(x2)
    );
    dsm3_integ #(.SW(SW), .AW(AW)) integ3_i (
        .clk(clk), .rst(rst), .en(smp_vld_i), .add(add3), .st(x3)
    );

    dsm3_ctrl ctrl_i (
        .clk(clk), .rst(rst), .smp_vld(smp_vld_i), .cal_en(cal_en_i), .q(q),
        .state(state), .bit_o(bit_o), .bit_vld(bit_vld_o)
    );

    assert_vld_follows_R2: assert property (@(posedge clk) disable iff (rst)
        smp_vld_i |=> bit_vld_o);

    assert_no_sample_R2: assert property (@(posedge clk) disable iff (rst)
        !smp_vld_i |=> !bit_vld_o);

    assert_tone_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (smp_vld_i && !cal_en_i) |=> (bit_o == !$past(x3[SW-1])));

    assert_reset_out_R1: assert property (@(posedge clk) rst |=> (!bit_o && !bit_vld_o));

endmodule

// File: tb/dsm3_notch_mod_tb.sv
module dsm3_notch_mod_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_vld = 1'b0;
    logic signed [15:0] smp = '0;
    logic cal_en = 1'b0;
    logic signed [15:0] tone = '0;
    logic bit_a, vld_a, bit_b, vld_b;

    int n_chk = 0;
    int n_fail = 0;
    longint xm [2][3];
    logic prev_bit [2];
    bit sat_seen = 0;

    always #5 clk = ~clk;

    dsm3_notch_mod dut_i (
        .clk(clk), .rst(rst), .smp_vld_i(smp_vld), .smp_i(smp),
        .cal_en_i(cal_en), .tone_i(tone), .bit_o(bit_a), .bit_vld_o(vld_a)
    );

    dsm3_notch_mod #(.K1_PCT(50)) dut_half_i (
        .clk(clk), .rst(rst), .smp_vld_i(smp_vld), .smp_i(smp),
        .cal_en_i(cal_en), .tone_i(tone), .bit_o(bit_b), .bit_vld_o(vld_b)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint sat32(longint v);
        if (v > 64'sd2147483647) begin
            sat_seen = 1;
            return 64'sd2147483647;
        end
        if (v < -64'sd2147483648) begin
            sat_seen = 1;
            return -64'sd2147483648;
        end
        return v;
    endfunction

    function automatic logic model_step(int m, longint u, bit c, longint t);
        longint k1, y, v, n1, n2, n3;
        k1 = (m == 0) ? 5243 : (5243 * 50) / 100;
        y  = xm[m][2] + (c ? t * 512 : 0);
        v  = (y >= 0) ? 1 : -1;
        n1 = xm[m][0] + u * 58 * 2 - v * 108 * 65536;
        n2 = xm[m][1] + xm[m][0] - v * 156 * 65536 - ((xm[m][2] * k1) >>> 24);
        n3 = xm[m][2] + ((xm[m][1] * 48) >>> 8) - v * 80 * 65536;
        xm[m][0] = sat32(n1);
        xm[m][1] = sat32(n2);
        xm[m][2] = sat32(n3);
        return (y >= 0);
    endfunction

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 3; i++) xm[m][i] = 0;
            prev_bit[m] = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_vld = 1'b0; cal_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic step(int u, bit c, int t, string req);
        logic ea, eb;
        @(negedge clk);
        smp = 16'(u); cal_en = c; tone = 16'(t); smp_vld = 1'b1;
        ea = model_step(0, u, c, t);
        eb = model_step(1, u, c, t);
        @(posedge clk); #1;
        chk(req, bit_a, ea);
        chk(req, bit_b, eb);
        chk("R2", vld_a, 1'b1);
        prev_bit[0] = ea; prev_bit[1] = eb;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic idle_step(string req);
        @(negedge clk);
        smp_vld = 1'b0; smp = 16'sd12345; tone = 16'sd20000; cal_en = 1'b1;
        @(posedge clk); #1;
        chk("R2", vld_a, 1'b0);
        chk(req, bit_a, prev_bit[0]);
        chk(req, bit_b, prev_bit[1]);
    endtask

    function automatic int sine_val(int n, real amp);
        return $rtoi(amp * $sin(2.0 * 3.14159265358979 * n / 256.0));
    endfunction

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1", bit_a, 1'b0);
        chk("R1", vld_a, 1'b0);
        chk("R1", bit_b, 1'b0);
    endtask

    task automatic t_latency();
        do_reset();
        step(0, 0, 0, "R3");
        idle_step("R9");
        @(negedge clk);
        chk("R11", vld_a, 1'b0);
    endtask

    task automatic t_zero();
        do_reset();
        for (int n = 0; n < 512; n++) step(0, 0, 0, "R4/R5/R6");
    endtask

    task automatic t_dc();
        do_reset();
        for (int n = 0; n < 1024; n++) step(16384, 0, 0, "R4/R5/R6");
        for (int n = 0; n < 1024; n++) step(-24576, 0, 0, "R4/R5/R6");
    endtask

    task automatic t_sine();
        do_reset();
        for (int n = 0; n < 1024; n++) step(sine_val(n, 13000.0), 0, 0, "R5 R10");
    endtask

    task automatic t_fullscale();
        do_reset();
        sat_seen = 0;
        for (int n = 0; n < 1500; n++) step(32767, 0, 0, "R7");
        for (int n = 0; n < 1500; n++) step(-32768, 0, 0, "R7");
        if (!sat_seen) $display("note: saturation not reached in R7 scenario");
    endtask

    task automatic t_cal();
        do_reset();
        for (int n = 0; n < 1024; n++) step(0, 1, sine_val(n, 16384.0), "R8");
        for (int n = 0; n < 512; n++) step(2000, 0, sine_val(n, 30000.0), "R8");
    endtask

    task automatic t_gap();
        do_reset();
        for (int n = 0; n < 300; n++) begin
            step(sine_val(n, 9000.0), n[0], sine_val(n, 8000.0), "R9");
            if (n % 3 == 0) idle_step("R9");
        end
    endtask

    task automatic t_mid_reset();
        for (int n = 0; n < 100; n++) step(5000, 0, 0, "R1");
        do_reset();
        #1;
        chk("R1", bit_a, 1'b0);
        for (int n = 0; n < 200; n++) step(0, 0, 0, "R1");
    endtask

    initial begin
        t_reset();
        t_latency();
        t_zero();
        t_dc();
        t_sine();
        t_fullscale();
        t_cal();
        t_gap();
        t_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule